// File: doc/BRIEF.md
# Tick-Based Watchdog Timer with Register Access

This block is a watchdog timer that software controls through a small 32-bit register bus: an address, a write strobe, write data and combinational read data. A programmable prescaler turns the input clock into a slow tick, normally one millisecond. Each tick advances a 16-bit up-counter from zero toward a programmed threshold. When the counter reaches the threshold while running, the block can drive a fixed-length reset pulse to the rest of the system. Software prevents this by writing the restart register before the threshold is reached.

The tick depends on three separate enables: the prescaler enable, the tick-clock enable and the run enable. The count register is packed. Its low half is the writable threshold and its high half shows the live count, so software can work out the time left as threshold minus count. For a 1 ms tick the divisor is set to the input clock rate divided by 1000.

Top module: `tick_watchdog`

## Requirements
- R1: After synchronous reset, the control register, threshold and counter are all zero, every register reads zero and the reset output is low.
- R2: The control register is at offset 0x0. Bits 17:0 are the divisor, bit 18 is run, bit 21 is reset-enable, bit 24 is tick-clock enable and bit 25 is prescaler enable. These bits read back as written and all other bits read zero. The restart register (0xC) and unmapped offsets read zero.
- R3: The count register is at offset 0x8. Writes set the threshold from bits 15:0 and ignore bits 31:16. Reads return the threshold in bits 15:0 and the live count in bits 31:16.
- R4: With bits 24, 25 and 18 set and divisor D nonzero, the counter goes up by exactly one every D clock cycles. A divisor of zero produces no ticks.
- R5: If bit 24 or bit 25 is clear, no ticks are produced and the counter holds.
- R6: Clearing bit 18 freezes the counter and setting it again resumes counting. The other control fields keep their values.
- R7: A write of any data to offset 0xC clears the counter and restarts the prescaler phase, so the next increment comes a full D cycles after the write edge.
- R8: When the count equals or exceeds the threshold while running, the counter holds its value and never goes past it.
- R9: When bit 21 is set, reaching the threshold raises the reset output for exactly PULSE_CYC cycles, starting one cycle after the counter reaches the threshold, and only once per expiry. When bit 21 is clear, the output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the offset on bus_addr (combinational) |
| sys_rst_o | output | 1 | System reset pulse on expiry |

## Verification
Some properties are checked on every cycle: a restart clears the count on the next edge, the count never moves by more than one, a stopped or expired counter holds, a written threshold takes the low half of the data, the prescaler phase returns to zero after a tick or while gated, and a reset pulse only starts when reset-enable was set. Other behaviour is only visible in the bench scenarios: exact tick spacing for a given divisor, the full-period delay after a restart, the exact pulse length and start cycle, that only one pulse occurs per expiry, and that control fields are kept across a pause.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DATA_W = 32;
    localparam int DIV_W  = 18;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFF_CTRL    = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_COUNT   = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_RESTART = 4'hC;

    localparam int BIT_RUN    = 18;
    localparam int BIT_RSTEN  = 21;
    localparam int BIT_TCLKEN = 24;
    localparam int BIT_PSCEN  = 25;

    typedef struct packed {
        logic             psc_en;
        logic             tclk_en;
        logic             rst_en;
        logic             run;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DIV_W-1:0]  = c.div;
        w[BIT_RUN]    = c.run;
        w[BIT_RSTEN]  = c.rst_en;
        w[BIT_TCLKEN] = c.tclk_en;
        w[BIT_PSCEN]  = c.psc_en;
        return w;
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.div     = w[DIV_W-1:0];
        c.run     = w[BIT_RUN];
        c.rst_en  = w[BIT_RSTEN];
        c.tclk_en = w[BIT_TCLKEN];
        c.psc_en  = w[BIT_PSCEN];
        return c;
    endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [CNT_W-1:0]  live_cnt,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  thr,
    output logic              restart
);
    logic unused_wbits;
    assign unused_wbits = ^wdata;

    logic hit_ctrl, hit_cnt;
    assign hit_ctrl = we && (addr == OFF_CTRL);
    assign hit_cnt  = we && (addr == OFF_COUNT);
    assign restart  = we && (addr == OFF_RESTART);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            thr  <= '0;
        end else begin
            if (hit_ctrl) ctrl <= ctrl_unpack(wdata);
            if (hit_cnt)  thr  <= wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        case (addr)
            OFF_CTRL:  rdata = ctrl_pack(ctrl);
            OFF_COUNT: rdata = {live_cnt, thr};
            default:   rdata = '0;
        endcase
    end

    assert_thr_low_half_R3: assert property (@(posedge clk) disable iff (rst)
        hit_cnt |=> thr == $past(wdata[CNT_W-1:0]));
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic             psc_en,
    input  logic             tclk_en,
    input  logic             resync,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] phase;
    logic             active;

    assign active = psc_en && tclk_en && (div != '0);
    assign tick   = active && (phase >= div - ONE);

    always_ff @(posedge clk) begin
        if (rst || resync || !active || tick) phase <= '0;
        else                                  phase <= phase + ONE;
    end

    assert_tick_rewinds_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> phase == '0);
    assert_gated_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (!psc_en || !tclk_en) |=> phase == '0);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int PULSE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             rst_en,
    input  logic             restart,
    input  logic [CNT_W-1:0] thr,
    output logic [CNT_W-1:0] cnt,
    output logic             sys_rst_o
);
    localparam int PW = $clog2(PULSE_CYC + 1);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [PW-1:0] PLEN = PW'(PULSE_CYC);

    logic          hit, hit_q, fire;
    logic [PW-1:0] pulse;

    assign hit  = run && (cnt >= thr);
    assign fire = hit && !hit_q && rst_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            hit_q <= 1'b0;
            pulse <= '0;
        end else begin
            if (restart)                 cnt <= '0;
            else if (run && tick && !hit) cnt <= cnt + ONE;
            hit_q <= hit;
            if (fire)              pulse <= PLEN;
            else if (pulse != '0)  pulse <= pulse - PW'(1);
        end
    end

    assign sys_rst_o = (pulse != '0);

    assert_restart_clears_R7: assert property (@(posedge clk) disable iff (rst)
        restart |=> cnt == '0);
    assert_frozen_when_stopped_R6: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> cnt == $past(cnt));
    assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
        !restart |=> (cnt == $past(cnt) || cnt == $past(cnt) + ONE));
    assert_hold_at_limit_R8: assert property (@(posedge clk) disable iff (rst)
        (hit && !restart) |=> cnt == $past(cnt));
    assert_pulse_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_o) |-> $past(rst_en));
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
    import wdt_pkg::*;
#(
    parameter int PULSE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sys_rst_o
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] thr, cnt;
    logic             restart, tick;

    wdt_regs u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .rdata(bus_rdata), .live_cnt(cnt), .ctrl(ctrl), .thr(thr), .restart(restart)
    );

    wdt_prescale u_psc (
        .clk(clk), .rst(rst), .div(ctrl.div), .psc_en(ctrl.psc_en),
        .tclk_en(ctrl.tclk_en), .resync(restart), .tick(tick)
    );

    wdt_core #(.PULSE_CYC(PULSE_CYC)) u_core (
        .clk(clk), .rst(rst), .tick(tick), .run(ctrl.run), .rst_en(ctrl.rst_en),
        .restart(restart), .thr(thr), .cnt(cnt), .sys_rst_o(sys_rst_o)
    );
endmodule

// File: tb/tick_watchdog_test.sv
module tick_watchdog_test;
    localparam int CLK_PERIOD = 10;
    localparam int PULSE = 4;
    localparam logic [3:0] A_CTRL = 4'h0, A_CNT = 4'h8, A_RST = 4'hC;

    logic        clk = 0, rst = 1, we = 0;
    logic [3:0]  addr = 0;
    logic [31:0] wdata = 0, rdata;
    logic        sys_rst;
    int checks = 0, errors = 0;

    tick_watchdog #(.PULSE_CYC(PULSE)) uut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .sys_rst_o(sys_rst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {addr, write data, expected read-back at same addr}
    localparam logic [67:0] VEC [0:7] = '{
        {4'h0, 32'h0000_0005, 32'h0000_0005},
        {4'h0, 32'hFFFF_FFFF, 32'h0327_FFFF},
        {4'h0, 32'h0000_0000, 32'h0000_0000},
        {4'h8, 32'hABCD_1234, 32'h0000_1234},
        {4'h8, 32'h0000_FFFF, 32'h0000_FFFF},
        {4'hC, 32'hDEAD_BEEF, 32'h0000_0000},
        {4'h0, 32'h0204_0000, 32'h0204_0000},
        {4'h4, 32'h0000_1234, 32'h0000_0000}
    };

    function automatic logic [31:0] mk_ctrl(input int div, input bit run,
        input bit rsten, input bit tclk, input bit psc);
        logic [31:0] w;
        w = 32'(div) & 32'h3FFFF;
        w[18] = run; w[21] = rsten; w[24] = tclk; w[25] = psc;
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1;
        @(posedge clk);
        @(negedge clk); we = 0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r, v;
        int highs, first;
        repeat (5) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        bus_read(A_CTRL, r); check("R1 ctrl", r, 0);
        bus_read(A_CNT, r);  check("R1 count", r, 0);
        bus_read(A_RST, r);  check("R1 restart", r, 0);
        check("R1 sysrst", {31'b0, sys_rst}, 0);

        // R2/R3 register table
        for (int i = 0; i < 8; i++) begin
            bus_write(VEC[i][67:64], VEC[i][63:32]);
            bus_read(VEC[i][67:64], r);
            check(i < 3 || i > 4 ? "R2 readback" : "R3 readback", r, VEC[i][31:0]);
        end

        // R4 counting with divisor 4
        bus_write(A_CTRL, 0); bus_write(A_RST, 0); bus_write(A_CNT, 100);
        bus_write(A_CTRL, mk_ctrl(4, 1, 0, 1, 1));
        wait_cyc(11);
        bus_read(A_CNT, r); check("R4 count before 3rd tick", r[31:16], 2);
        wait_cyc(1);
        bus_read(A_CNT, r); check("R4 count after 12 cycles", r[31:16], 3);
        check("R3 remaining", 32'(r[15:0] - r[31:16]), 97);

        // R7 restart and full period
        bus_write(A_RST, 32'h1234_5678);
        bus_read(A_CNT, r); check("R7 cleared", r[31:16], 0);
        wait_cyc(3);
        bus_read(A_CNT, r); check("R7 no early tick", r[31:16], 0);
        wait_cyc(1);
        bus_read(A_CNT, r); check("R7 tick after full period", r[31:16], 1);

        // R6 pause and resume
        bus_write(A_CTRL, mk_ctrl(4, 0, 0, 1, 1));
        bus_read(A_CNT, r); v = r;
        wait_cyc(20);
        bus_read(A_CNT, r); check("R6 frozen", r[31:16], v[31:16]);
        bus_read(A_CTRL, r); check("R6 fields kept", r, mk_ctrl(4, 0, 0, 1, 1));
        bus_write(A_CTRL, mk_ctrl(4, 1, 0, 1, 1));
        wait_cyc(8);
        bus_read(A_CNT, r);
        check("R6 resumed", {31'b0, (r[31:16] > v[31:16]) && (r[31:16] <= v[31:16] + 3)}, 1);

        // R5 gating
        bus_write(A_CTRL, mk_ctrl(4, 1, 0, 0, 1));
        bus_read(A_CNT, v); wait_cyc(20); bus_read(A_CNT, r);
        check("R5 tick clock off", r[31:16], v[31:16]);
        bus_write(A_CTRL, mk_ctrl(4, 1, 0, 1, 0));
        bus_read(A_CNT, v); wait_cyc(20); bus_read(A_CNT, r);
        check("R5 prescaler off", r[31:16], v[31:16]);
        bus_write(A_CTRL, mk_ctrl(0, 1, 0, 1, 1));
        bus_read(A_CNT, v); wait_cyc(20); bus_read(A_CNT, r);
        check("R4 divisor zero", r[31:16], v[31:16]);

        // R8/R9 expiry with pulse
        bus_write(A_CTRL, 0); bus_write(A_RST, 0); bus_write(A_CNT, 3);
        bus_write(A_CTRL, mk_ctrl(2, 1, 1, 1, 1));
        wait_cyc(6);
        bus_read(A_CNT, r); check("R8 reached limit", r[31:16], 3);
        check("R9 not yet", {31'b0, sys_rst}, 0);
        highs = 0; first = 0;
        for (int i = 0; i < 20; i++) begin
            wait_cyc(1);
            if (sys_rst) highs++;
            if (i == 0) first = int'(sys_rst);
        end
        check("R9 pulse start", 32'(first), 1);
        check("R9 pulse length", 32'(highs), PULSE);
        bus_read(A_CNT, r); check("R8 held at limit", r[31:16], 3);

        // R9 disabled
        bus_write(A_CTRL, 0); bus_write(A_RST, 0); bus_write(A_CNT, 2);
        bus_write(A_CTRL, mk_ctrl(1, 1, 0, 1, 1));
        highs = 0;
        for (int i = 0; i < 15; i++) begin
            wait_cyc(1);
            if (sys_rst) highs++;
        end
        check("R9 no pulse when disabled", 32'(highs), 0);
        bus_read(A_CNT, r); check("R8 held without pulse", r[31:16], 2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule